// File: doc/BRIEF.md
# Asynchronous Serial Channel with Status Flags

This block is one full-duplex asynchronous serial channel that sits on a byte-wide register bus. Software sets the character format and the bit rate, places a byte in the transmit holding register, and hands it over by clearing the "transmit register empty" flag. The channel then serialises the byte onto a line that idles high. On the receive side, it watches a single input line, samples each bit near its centre using a 16x tick, and places completed characters in a receive holding register.

The character format is chosen per frame from the mode register: 7 or 8 data bits, an optional even or odd parity bit, and one or two stop bits. Every frame begins with a low start bit. The bit period is 32 x D x B system clocks. B is the rate register value, with 0 treated as 1. D is 1, 4, 16 or 64, selected by mode bits 1:0.

Status flags are set by hardware and can only be cleared by software, which writes 0 to the flag's bit position. They cover: transmit holding register empty, transmission finished, receive data full, overrun, and parity mismatch.

Top module: `uart_stat_core`

## Requirements
- R1: After reset the status register reads 0x84, every other register reads 0x00, and `tx_out` is high.
- R2: Registers sit at these addresses: mode 0, rate 1, control 2, transmit data 3, status 4, receive data 5. Addresses 6 and 7 read 0x00. Mode, rate, control and transmit data read back the last value written. `reg_rdata` shows the register addressed in the previous cycle.
- R3: The status bits are: 7 transmit empty (TE flag), 6 receive full, 5 overrun, 3 parity error, 2 transmit end. Bits 4, 1 and 0 read 0. A status write with a 0 at a flag's position clears that flag. A 1 at that position leaves the flag unchanged, so software can never set a flag.
- R4: One bit lasts 32 x D x max(B,1) clocks. D is 1, 4, 16 or 64 for mode bits 1:0 = 0, 1, 2, 3, and B is the rate register value.
- R5: A transmitted frame is sent in this order:
  - a low start bit;
  - the data bits, LSB first: 7 when mode bit 6 is set, else 8;
  - a parity bit, if mode bit 5 is set;
  - a high stop bit, plus a second high stop bit when mode bit 3 is set.
  
  The parity bit makes the count of ones even when mode bit 4 is clear and odd when it is set. `tx_out` is high whenever no frame is being sent.
- R6: When control bit 5 is set, the transmit-empty flag is clear and the transmitter is idle, the transmit data byte is taken on the next clock edge. On that edge the transmit-empty flag sets again and the start bit begins. Clearing the transmit-empty flag also clears transmit end.
- R7: Transmit end sets when the final stop bit of a frame finishes, provided transmit empty is still set at that moment.
- R8: With control bit 4 set, a received frame in the current format loads the receive data register and sets receive full. In 7-bit mode, bit 7 of the stored byte is 0.
- R9: If a frame completes while receive full is already set, the overrun flag sets instead, and the receive data register keeps its earlier byte.
- R10: When parity is enabled and a received frame's parity bit does not match the selected sense, the parity error flag sets along with receive full.
- R11: A low pulse on `rx_in` that has ended by the middle of the would-be start bit does not start a frame.
- R12: While control bit 4 is clear, frames on `rx_in` neither load the receive data register nor change any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line, idles high |

## Verification
A wrong transmit shift state or bit counter shows up in the frame itself. A bit is wrong at a mid-bit sample, or the frame has the wrong length, which means the transmit-end flag rises at the wrong time or not at all, one frame later. A drifting rate divider shows up as a wrong interval between two falling edges inside one character. A receiver that loses its place shows up in the next status read after the frame: wrong data, a missing receive-full flag, or a spurious overrun or parity flag. A flag register that does not hold its value, or that can be set by software, shows up in the very next status read.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int OS_LOG2 = 4;           // 16 ticks per bit
  localparam int ADR_MODE = 0;
  localparam int ADR_RATE = 1;
  localparam int ADR_CTRL = 2;
  localparam int ADR_TXD  = 3;
  localparam int ADR_STAT = 4;
  localparam int ADR_RXD  = 5;
  localparam int ST_TDRE = 7;
  localparam int ST_RDRF = 6;
  localparam int ST_ORER = 5;
  localparam int ST_PER  = 3;
  localparam int ST_TEND = 2;
  localparam int MD_LEN7  = 6;
  localparam int MD_PAR   = 5;
  localparam int MD_ODD   = 4;
  localparam int MD_STOP2 = 3;
  localparam int CT_TXEN  = 5;
  localparam int CT_RXEN  = 4;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
endpackage

// File: rtl/uart_stat_baud.sv
module uart_stat_baud #(
  parameter int RATE_W = 8,
  parameter int CNT_W  = RATE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        div_sel,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] rate_eff;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  cnt;

  // tick period = 2 * 4^div_sel * max(rate,1); 16 ticks make one bit
  always_comb begin
    rate_eff = (rate == '0) ? RATE_W'(1) : rate;
    period   = CNT_W'(rate_eff) << {div_sel, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= period - CNT_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_stat_tx.sv
module uart_stat_tx
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt,
  output logic              tx_out,
  output logic              busy,
  output logic              done
);
  localparam int FR_W  = DATA_W + 4;
  localparam int LEN_W = $clog2(FR_W + 1);

  logic [FR_W-1:0]    frame, sh;
  logic [LEN_W-1:0]   nbits, left;
  logic [OS_LOG2-1:0] tcnt;

  always_comb begin
    int dl;
    logic [DATA_W-1:0] mask;
    dl    = fmt.len7 ? DATA_W - 1 : DATA_W;
    mask  = fmt.len7 ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < dl) frame[1+i] = data[i];
    if (fmt.par_en) frame[1+dl] = (^(data & mask)) ^ fmt.par_odd;
    nbits = LEN_W'(2 + dl) + LEN_W'(fmt.par_en) + LEN_W'(fmt.stop2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '1;
      left   <= '0;
      tcnt   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      tx_out <= 1'b1;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        sh     <= frame;
        tx_out <= frame[0];
        left   <= nbits;
        tcnt   <= '0;
        busy   <= 1'b1;
      end else if (busy && tick) begin
        if (tcnt == '1) begin
          tcnt <= '0;
          if (left == LEN_W'(1)) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            tx_out <= 1'b1;
            sh     <= '1;
          end else begin
            sh     <= {1'b1, sh[FR_W-1:1]};
            tx_out <= sh[1];
          end
          left <= left - LEN_W'(1);
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_stat_rx.sv
module uart_stat_rx
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              len7,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_in,
  output logic              done,
  output logic [DATA_W-1:0] data_out,
  output logic              perr
);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam int HALF  = 2 ** (OS_LOG2 - 1);

  rx_st_t             state;
  logic [1:0]         sync;
  logic               rx_s;
  logic [OS_LOG2-1:0] tcnt;
  logic [IDX_W-1:0]   idx, last, pidx;
  logic [DATA_W:0]    bits;
  logic [DATA_W-1:0]  dbyte;
  logic               perr_c;

  assign rx_s = sync[1];

  always_comb begin
    logic [DATA_W-1:0] mask;
    mask   = len7 ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    pidx   = len7 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W);
    last   = pidx + IDX_W'(par_en) - IDX_W'(1);
    dbyte  = bits[DATA_W-1:0] & mask;
    perr_c = par_en && (bits[pidx] != ((^dbyte) ^ par_odd));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      state    <= RX_IDLE;
      tcnt     <= '0;
      idx      <= '0;
      bits     <= '0;
      done     <= 1'b0;
      data_out <= '0;
      perr     <= 1'b0;
    end else begin
      sync <= {sync[0], rx_in};
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: if (!rx_s) begin
            state <= RX_START;
            tcnt  <= '0;
          end
          RX_START: if (tcnt == OS_LOG2'(HALF - 1)) begin
            tcnt  <= '0;
            idx   <= '0;
            state <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          RX_DATA: if (tcnt == '1) begin
            tcnt      <= '0;
            bits[idx] <= rx_s;
            if (idx == last) state <= RX_STOP;
            else idx <= idx + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          default: if (tcnt == '1) begin
            tcnt     <= '0;
            state    <= RX_IDLE;
            done     <= 1'b1;
            data_out <= dbyte;
            perr     <= perr_c;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_stat_core.sv
module uart_stat_core
  import uart_stat_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_in,
  output logic              tx_out
);
  logic [DATA_W-1:0] mode_q, rate_q, ctrl_q, tdr_q, rdr_q, stat_v;
  logic st_tdre, st_rdrf, st_orer, st_per, st_tend;
  logic tick, tx_busy, tx_done, start_tx, rx_done, rx_perr;
  logic [DATA_W-1:0] rx_data;
  logic wr_stat, clr_tdre;
  fmt_t fmt;

  assign fmt.len7    = mode_q[MD_LEN7];
  assign fmt.par_en  = mode_q[MD_PAR];
  assign fmt.par_odd = mode_q[MD_ODD];
  assign fmt.stop2   = mode_q[MD_STOP2];

  assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(ADR_STAT));
  assign clr_tdre = wr_stat && !reg_wdata[ST_TDRE];
  assign start_tx = ctrl_q[CT_TXEN] && !st_tdre && !tx_busy;

  uart_stat_baud #(.RATE_W(DATA_W)) u_baud (
    .clk(clk), .rst(rst), .div_sel(mode_q[1:0]), .rate(rate_q), .tick(tick)
  );

  uart_stat_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(start_tx), .data(tdr_q),
    .fmt(fmt), .tx_out(tx_out), .busy(tx_busy), .done(tx_done)
  );

  uart_stat_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(ctrl_q[CT_RXEN]),
    .len7(fmt.len7), .par_en(fmt.par_en), .par_odd(fmt.par_odd),
    .rx_in(rx_in), .done(rx_done), .data_out(rx_data), .perr(rx_perr)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rate_q <= '0;
      ctrl_q <= '0;
      tdr_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(ADR_MODE): mode_q <= reg_wdata;
        ADDR_W'(ADR_RATE): rate_q <= reg_wdata;
        ADDR_W'(ADR_CTRL): ctrl_q <= reg_wdata;
        ADDR_W'(ADR_TXD):  tdr_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  // status flags: hardware sets win, software may only clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_tdre <= 1'b1;
      st_tend <= 1'b1;
      st_rdrf <= 1'b0;
      st_orer <= 1'b0;
      st_per  <= 1'b0;
      rdr_q   <= '0;
    end else begin
      if (start_tx)      st_tdre <= 1'b1;
      else if (clr_tdre) st_tdre <= 1'b0;

      if (tx_done && st_tdre && !clr_tdre)           st_tend <= 1'b1;
      else if (clr_tdre || start_tx)                 st_tend <= 1'b0;
      else if (wr_stat && !reg_wdata[ST_TEND])       st_tend <= 1'b0;

      if (wr_stat && !reg_wdata[ST_RDRF]) st_rdrf <= 1'b0;
      if (wr_stat && !reg_wdata[ST_ORER]) st_orer <= 1'b0;
      if (wr_stat && !reg_wdata[ST_PER])  st_per  <= 1'b0;

      if (rx_done && ctrl_q[CT_RXEN]) begin
        if (st_rdrf) begin
          st_orer <= 1'b1;
        end else begin
          rdr_q   <= rx_data;
          st_rdrf <= 1'b1;
          if (rx_perr) st_per <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stat_v = '0;
    stat_v[ST_TDRE] = st_tdre;
    stat_v[ST_RDRF] = st_rdrf;
    stat_v[ST_ORER] = st_orer;
    stat_v[ST_PER]  = st_per;
    stat_v[ST_TEND] = st_tend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(ADR_MODE): reg_rdata <= mode_q;
        ADDR_W'(ADR_RATE): reg_rdata <= rate_q;
        ADDR_W'(ADR_CTRL): reg_rdata <= ctrl_q;
        ADDR_W'(ADR_TXD):  reg_rdata <= tdr_q;
        ADDR_W'(ADR_STAT): reg_rdata <= stat_v;
        ADDR_W'(ADR_RXD):  reg_rdata <= rdr_q;
        default:           reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_out,
  input logic              tx_busy,
  input logic              tdre,
  input logic              tend,
  input logic              rdrf,
  input logic              orer,
  input logic              rx_done,
  input logic [DATA_W-1:0] rdr
);
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_out);

  a_r5_frame_starts_low: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !tx_out);

  a_r6_take_sets_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> tdre);

  a_r7_end_needs_empty: assert property (@(posedge clk) disable iff (rst)
    tend |-> tdre);

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(orer) |-> $past(rx_done && rdrf));

  a_r9_data_held_while_full: assert property (@(posedge clk) disable iff (rst)
    $past(rdrf) |-> $stable(rdr));
endmodule

bind uart_stat_core uart_stat_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx_out(tx_out), .tx_busy(tx_busy),
  .tdre(st_tdre), .tend(st_tend), .rdrf(st_rdrf), .orer(st_orer),
  .rx_done(rx_done), .rdr(rdr_q)
);

// File: tb/sim_uart_stat_core.sv
module sim_uart_stat_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] a = '0;
  logic       w = 1'b0;
  logic [7:0] d = '0;
  logic [7:0] q;
  logic       rx = 1'b1;
  logic       tx;
  longint     cyc = 0;
  int         checks = 0;
  int         fails = 0;

  uart_stat_core u0 (.clk(clk), .rst(rst), .reg_addr(a), .reg_wr(w),
    .reg_wdata(d), .reg_rdata(q), .rx_in(rx), .tx_out(tx));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] v);
    @(negedge clk); a = ad; d = v; w = 1'b1;
    @(negedge clk); w = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output logic [7:0] v);
    @(negedge clk); a = ad;
    @(negedge clk); v = q;
  endtask

  task automatic wait_until(input longint t);
    while (cyc < t) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic next_fall(output longint t);
    while (tx == 1'b0) @(negedge clk);
    while (tx == 1'b1) @(negedge clk);
    t = cyc;
  endtask

  function automatic int flen(input logic [7:0] md);
    return 2 + (md[6] ? 7 : 8) + int'(md[5]) + int'(md[3]);
  endfunction

  function automatic logic [11:0] fvec(input logic [7:0] b, input logic [7:0] md, input bit flip);
    logic [11:0] v;
    int dl;
    dl = md[6] ? 7 : 8;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < dl) v[1+i] = b[i];
    if (md[5]) v[1+dl] = (^(b & (md[6] ? 8'h7f : 8'hff))) ^ md[4] ^ flip;
    return v;
  endfunction

  task automatic send_rx(input logic [7:0] b, input logic [7:0] md, input bit flip, input int bitp);
    logic [11:0] v;
    v = fvec(b, md, flip);
    for (int k = 0; k < flen(md); k++) begin
      @(negedge clk); rx = v[k];
      repeat (bitp - 1) @(negedge clk);
    end
    @(negedge clk); rx = 1'b1;
    repeat (bitp) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, md;
    logic [11:0] fr;
    longint t0, t1, t2;
    logic [7:0] pat [4];
    int bitp;
    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h5A; pat[3] = 8'hC3;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd4, v); chk("R1 status", v, 8'h84);
    rd(3'd0, v); chk("R1 mode", v, 8'h00);
    rd(3'd5, v); chk("R1 rxdata", v, 8'h00);
    chk("R1 tx idle", tx, 1);

    // R2 register readback
    wr(3'd0, 8'h4A); wr(3'd1, 8'h37); wr(3'd2, 8'h0C); wr(3'd3, 8'hA5);
    rd(3'd0, v); chk("R2 mode", v, 8'h4A);
    rd(3'd1, v); chk("R2 rate", v, 8'h37);
    rd(3'd2, v); chk("R2 ctrl", v, 8'h0C);
    rd(3'd3, v); chk("R2 txdata", v, 8'hA5);
    rd(3'd6, v); chk("R2 addr6", v, 8'h00);
    rd(3'd7, v); chk("R2 addr7", v, 8'h00);

    // R3 clear-only status writes
    wr(3'd2, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R3 ones keep", v, 8'h84);
    wr(3'd4, 8'h00); rd(3'd4, v); chk("R3 zero clears", v, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R3 cannot set", v, 8'h00);
    // R6 pending byte taken when transmitter enabled
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'h20);
    rd(3'd4, v); chk("R6 empty after take", v, 8'h80);
    repeat (400) @(negedge clk);
    rd(3'd4, v); chk("R7 end after frame", v, 8'h84);

    // R5 transmit format sweep, bit time 32 clocks
    bitp = 32;
    for (int f = 0; f < 16; f++) begin
      md = {1'b0, f[0], f[1], f[2], f[3], 3'b000};
      for (int bi = 0; bi < 4; bi++) begin
        wr(3'd0, md); wr(3'd3, pat[bi]); wr(3'd4, 8'h7F);
        next_fall(t0);
        rd(3'd4, v); chk("R6 empty set, end clear", v, 8'h80);
        fr = fvec(pat[bi], md, 1'b0);
        for (int k = 0; k < flen(md); k++) begin
          wait_until(t0 + longint'(k * bitp + bitp / 2));
          chk($sformatf("R5 fmt %0d byte %h bit %0d", f, pat[bi], k), tx, fr[k]);
        end
        wait_until(t0 + longint'(flen(md) * bitp + 8));
        rd(3'd4, v); chk("R7 end after last stop", v, 8'h84);
      end
    end

    // R4 bit period for several divider/rate settings, 8N1 byte 0x05
    for (int s = 0; s < 4; s++) begin
      logic [1:0] sel;
      logic [7:0] br;
      int dv;
      case (s)
        0: begin sel = 2'd1; br = 8'd2; end
        1: begin sel = 2'd2; br = 8'd1; end
        2: begin sel = 2'd0; br = 8'd0; end
        default: begin sel = 2'd3; br = 8'd1; end
      endcase
      dv = 1 << (2 * sel);
      bitp = 32 * dv * ((br == 0) ? 1 : int'(br));
      wr(3'd0, {6'd0, sel}); wr(3'd1, br); wr(3'd3, 8'h05); wr(3'd4, 8'h7F);
      next_fall(t0); next_fall(t1); next_fall(t2);
      chk($sformatf("R4 sel %0d rate %0d two-bit span", sel, br), t2 - t1, 2 * bitp);
      wait_until(t0 + longint'(10 * bitp + 8));
      rd(3'd4, v); chk("R7 end slow rate", v, 8'h84);
    end

    // R8/R10 receive sweep, bit time 32 clocks
    wr(3'd1, 8'h01); wr(3'd2, 8'h10);
    bitp = 32;
    for (int f = 0; f < 16; f++) begin
      md = {1'b0, f[0], f[1], f[2], f[3], 3'b000};
      wr(3'd0, md);
      for (int bi = 0; bi < 4; bi++) begin
        wr(3'd4, 8'h84);
        send_rx(pat[bi], md, 1'b0, bitp);
        rd(3'd4, v); chk($sformatf("R8 fmt %0d status", f), v, 8'hC4);
        rd(3'd5, v); chk($sformatf("R8 fmt %0d data", f), v, pat[bi] & (md[6] ? 8'h7F : 8'hFF));
        if (md[5]) begin
          wr(3'd4, 8'h84);
          send_rx(pat[bi], md, 1'b1, bitp);
          rd(3'd4, v); chk($sformatf("R10 fmt %0d parity flag", f), v, 8'hCC);
        end
      end
    end

    // R9 overrun
    wr(3'd0, 8'h00); wr(3'd4, 8'h84);
    send_rx(8'h11, 8'h00, 1'b0, bitp);
    send_rx(8'h22, 8'h00, 1'b0, bitp);
    rd(3'd4, v); chk("R9 overrun status", v, 8'hE4);
    rd(3'd5, v); chk("R9 data kept", v, 8'h11);
    wr(3'd4, 8'h84); rd(3'd4, v); chk("R3 rx flags cleared", v, 8'h84);

    // R11 short low pulse rejected
    @(negedge clk); rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (3 * bitp) @(negedge clk);
    rd(3'd4, v); chk("R11 glitch no frame", v, 8'h84);
    send_rx(8'h6B, 8'h00, 1'b0, bitp);
    rd(3'd5, v); chk("R11 next frame clean", v, 8'h6B);
    wr(3'd4, 8'h84);

    // R12 receiver disabled
    wr(3'd2, 8'h00);
    send_rx(8'h3C, 8'h00, 1'b0, bitp);
    rd(3'd4, v); chk("R12 no flags", v, 8'h84);
    rd(3'd5, v); chk("R12 data unchanged", v, 8'h6B);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule